// File: doc/BRIEF.md
# Bidirectional Cascadable Configuration Shift Chain

This block loads per-channel settings into a multi-channel display driver. Each channel owns a 6-bit word: a 4-bit pulse-width code and a 2-bit current-level code. The words travel through a chain of `NUM_CH` stages, one word per stage, with all six bits moving in parallel lanes. A data clock moves the chain by one stage on every cycle where `shift_en` is high. A strobe then copies the whole chain into a holding register. That register drives the channel logic, and the chain can be refilled in the background.

Either end of the chain can be the input. While `dir_rev` is low, words enter at the low end (stage 1) and move toward stage `NUM_CH`, and the high end drives the cascade output. While `dir_rev` is high the roles swap. Input data is taken on the rising clock edge and the cascade output changes on the falling edge, so identical chips can be chained in either direction. The current-level code is exported only: 0 means 0 %, 1 means 33 %, 2 means 66 % and 3 means 100 % of full scale.

A three-state controller holds the direction. `ST_CLEAR` is entered whenever reset is active. It moves to `ST_FWD` or `ST_REV` on the first clock edge after reset release, according to `dir_rev`. `ST_FWD` moves to `ST_REV` when `dir_rev` is sampled high. `ST_REV` moves to `ST_FWD` when `dir_rev` is sampled low. Otherwise each state stays where it is.

Top module: `cfg_chain_loader`

## Requirements
- R1: In `ST_FWD`, every rising `dclk` edge with `shift_en` high loads stage 1 from `end_lo_in` and loads each stage k>1 from stage k-1.
- R2: In `ST_REV`, every rising `dclk` edge with `shift_en` high loads stage `NUM_CH` from `end_hi_in` and loads each stage k<`NUM_CH` from stage k+1.
- R3: A change of `dir_rev` takes effect at the next rising edge. In `ST_FWD` only `end_hi_oe` is high. In `ST_REV` only `end_lo_oe` is high. In `ST_CLEAR` neither is high.
- R4: On each falling `dclk` edge, `end_hi_out` takes the content of stage `NUM_CH` and `end_lo_out` takes the content of stage 1. Two chips joined end to end therefore act as a single chain of 2·`NUM_CH` stages in either direction.
- R5: In every word, bits [3:0] are the pulse-width code and bits [5:4] are the current code. Channel c (counting from 0 at stage 1) appears at `pw_code[4c+3:4c]` and `cur_code[2c+1:2c]`. The current codes 0, 1, 2 and 3 mean 0 %, 33 %, 66 % and 100 %.
- R6: With `shift_en` low, no stage changes, whatever the pad inputs carry.
- R7: The holding register loads on a rising `dclk` edge where `stb` is high and was low at the previous edge. It captures the chain as it stood before any shift on that same edge.
- R8: While `stb` stays high, no further load happens, so the held values ignore later shifts.
- R9: A low `rst_n` clears all stages, the holding register and both pad outputs at once, and forces `ST_CLEAR`. Release takes effect after two rising `dclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| dir_rev | input | 1 | 0: low end is the input; 1: high end is the input |
| shift_en | input | 1 | Moves the chain by one stage on this rising edge |
| stb | input | 1 | Strobe; a rising level loads the holding register |
| end_lo_in | input | PW_W+CUR_W | Serial input at the stage-1 end |
| end_lo_out | output | PW_W+CUR_W | Cascade output at the stage-1 end |
| end_lo_oe | output | 1 | Drive enable for the stage-1 end |
| end_hi_in | input | PW_W+CUR_W | Serial input at the last-stage end |
| end_hi_out | output | PW_W+CUR_W | Cascade output at the last-stage end |
| end_hi_oe | output | 1 | Drive enable for the last-stage end |
| pw_code | output | NUM_CH*PW_W | Held pulse-width codes, channel-packed |
| cur_code | output | NUM_CH*CUR_W | Held current codes, channel-packed |

## Verification
The in-design properties assume that `dir_rev` is never changed on the same cycle as a shift. A reversed shift would otherwise start one edge later than a naive model expects. They also assume that `stb` is a clean level seen by the data clock. The stimulus always leaves idle cycles with `shift_en` low after a change of direction, and it changes `stb` only between edges. The two chips under test share `dclk`, `stb` and `dir_rev`, so the cascade path stays inside the same clock relation that the falling-edge output relies on.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FWD   = 2'd1,
        ST_REV   = 2'd2
    } chain_state_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_out_n
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) chain <= '0;
        else           chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_out_n = chain[STAGES-1];

endmodule

// File: rtl/cfg_shift_core.sv
module cfg_shift_core #(
    parameter int NUM_CH = 128,
    parameter int LANES  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     do_fwd,
    input  logic                     do_rev,
    input  logic [LANES-1:0]         lo_in,
    input  logic [LANES-1:0]         hi_in,
    output logic [NUM_CH*LANES-1:0]  stages_flat,
    output logic [LANES-1:0]         stage_lo,
    output logic [LANES-1:0]         stage_hi
);

    localparam int FLAT_W = NUM_CH * LANES;

    logic [LANES-1:0] sr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stage
        logic [LANES-1:0] from_lo;
        logic [LANES-1:0] from_hi;
        logic [LANES-1:0] q;

        if (g == 0) begin : g_lo_end
            assign from_lo = lo_in;
        end else begin : g_lo_mid
            assign from_lo = sr[g-1];
        end

        if (g == NUM_CH-1) begin : g_hi_end
            assign from_hi = hi_in;
        end else begin : g_hi_mid
            assign from_hi = sr[g+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= '0;
            else if (do_fwd) q <= from_lo;
            else if (do_rev) q <= from_hi;
        end

        assign sr[g] = q;
        assign stages_flat[g*LANES +: LANES] = q;
    end

    assign stage_lo = sr[0];
    assign stage_hi = sr[NUM_CH-1];

    assert_fwd_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        do_fwd |=> (stage_lo == $past(lo_in)));

    assert_fwd_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        do_fwd |=> (stages_flat[FLAT_W-1:LANES] == $past(stages_flat[FLAT_W-LANES-1:0])));

    assert_rev_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_rev |=> (stage_hi == $past(hi_in)));

    assert_rev_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_rev |=> (stages_flat[FLAT_W-LANES-1:0] == $past(stages_flat[FLAT_W-1:LANES])));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_fwd || do_rev) |=> $stable(stages_flat));

endmodule

// File: rtl/cfg_hold_latch.sv
module cfg_hold_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic stb_q;
    logic load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    assign load = stb & ~stb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    assert_load_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
    import cfg_pkg::*;
#(
    parameter int NUM_CH      = 128,
    parameter int PW_W        = 4,
    parameter int CUR_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      dclk,
    input  logic                      rst_n,
    input  logic                      dir_rev,
    input  logic                      shift_en,
    input  logic                      stb,
    input  logic [PW_W+CUR_W-1:0]     end_lo_in,
    output logic [PW_W+CUR_W-1:0]     end_lo_out,
    output logic                      end_lo_oe,
    input  logic [PW_W+CUR_W-1:0]     end_hi_in,
    output logic [PW_W+CUR_W-1:0]     end_hi_out,
    output logic                      end_hi_oe,
    output logic [NUM_CH*PW_W-1:0]    pw_code,
    output logic [NUM_CH*CUR_W-1:0]   cur_code
);

    localparam int LANES  = PW_W + CUR_W;
    localparam int FLAT_W = NUM_CH * LANES;

    logic               rst_sync_n;
    chain_state_e       state_q;
    chain_state_e       state_d;
    logic               do_fwd;
    logic               do_rev;
    logic [FLAT_W-1:0]  stage_flat;
    logic [FLAT_W-1:0]  held_flat;
    logic [LANES-1:0]   lo_stage;
    logic [LANES-1:0]   hi_stage;
    logic [LANES-1:0]   lo_q;
    logic [LANES-1:0]   hi_q;

    cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk       (dclk),
        .rst_in_n  (rst_n),
        .rst_out_n (rst_sync_n)
    );

    // Direction state register
    always_ff @(posedge dclk or negedge rst_sync_n) begin
        if (!rst_sync_n) state_q <= ST_CLEAR;
        else             state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: state_d = dir_rev ? ST_REV : ST_FWD;
            ST_FWD:   if (dir_rev)  state_d = ST_REV;
            ST_REV:   if (!dir_rev) state_d = ST_FWD;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // Per-state outputs: shift direction and pad drive enables
    always_comb begin
        do_fwd    = 1'b0;
        do_rev    = 1'b0;
        end_lo_oe = 1'b0;
        end_hi_oe = 1'b0;
        unique case (state_q)
            ST_FWD: begin
                do_fwd    = shift_en;
                end_hi_oe = 1'b1;
            end
            ST_REV: begin
                do_rev    = shift_en;
                end_lo_oe = 1'b1;
            end
            default: ;
        endcase
    end

    cfg_shift_core #(.NUM_CH(NUM_CH), .LANES(LANES)) u_core (
        .clk         (dclk),
        .rst_n       (rst_sync_n),
        .do_fwd      (do_fwd),
        .do_rev      (do_rev),
        .lo_in       (end_lo_in),
        .hi_in       (end_hi_in),
        .stages_flat (stage_flat),
        .stage_lo    (lo_stage),
        .stage_hi    (hi_stage)
    );

    cfg_hold_latch #(.WIDTH(FLAT_W)) u_hold (
        .clk   (dclk),
        .rst_n (rst_sync_n),
        .stb   (stb),
        .d     (stage_flat),
        .q     (held_flat)
    );

    // Cascade outputs change on the falling edge
    always_ff @(negedge dclk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_stage;
            hi_q <= hi_stage;
        end
    end

    assign end_lo_out = lo_q;
    assign end_hi_out = hi_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign pw_code[c*PW_W +: PW_W]    = held_flat[c*LANES +: PW_W];
        assign cur_code[c*CUR_W +: CUR_W] = held_flat[c*LANES+PW_W +: CUR_W];
    end

    assert_oe_exclusive_R3: assert property (@(posedge dclk) disable iff (!rst_sync_n)
        $onehot0({end_lo_oe, end_hi_oe}));

    assert_pad_tracks_R4: assert property (@(posedge dclk) disable iff (!rst_sync_n)
        (end_hi_out == hi_stage) && (end_lo_out == lo_stage));

    assert_clear_exit_R9: assert property (@(posedge dclk) disable iff (!rst_sync_n)
        (state_q == ST_CLEAR) |=> (state_q != ST_CLEAR));

endmodule

// File: tb/sim_cfg_chain_loader.sv
module sim_cfg_chain_loader;

    localparam int N  = 128;
    localparam int NN = 2 * N;

    logic dclk = 1'b0;
    always #2 dclk = ~dclk;

    logic       rst_n, dir_rev, shift_en, stb;
    logic [5:0] din;

    logic [5:0]     a_lo_out, a_hi_out, b_lo_out, b_hi_out;
    logic           a_lo_oe, a_hi_oe, b_lo_oe, b_hi_oe;
    logic [4*N-1:0] a_pw, b_pw;
    logic [2*N-1:0] a_cur, b_cur;

    cfg_chain_loader u0 (
        .dclk(dclk), .rst_n(rst_n), .dir_rev(dir_rev), .shift_en(shift_en), .stb(stb),
        .end_lo_in(din), .end_lo_out(a_lo_out), .end_lo_oe(a_lo_oe),
        .end_hi_in(b_lo_out), .end_hi_out(a_hi_out), .end_hi_oe(a_hi_oe),
        .pw_code(a_pw), .cur_code(a_cur)
    );

    cfg_chain_loader u1 (
        .dclk(dclk), .rst_n(rst_n), .dir_rev(dir_rev), .shift_en(shift_en), .stb(stb),
        .end_lo_in(a_hi_out), .end_lo_out(b_lo_out), .end_lo_oe(b_lo_oe),
        .end_hi_in(din), .end_hi_out(b_hi_out), .end_hi_oe(b_hi_oe),
        .pw_code(b_pw), .cur_code(b_cur)
    );

    int         vectors = 0;
    int         miscompares = 0;
    logic [5:0] m   [NN];
    logic [5:0] lat [NN];
    logic       stb_prev = 1'b0;
    bit         pad_chk  = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NN; i++) begin
            m[i]   = '0;
            lat[i] = '0;
        end
        stb_prev = 1'b0;
    endtask

    // Called at posedge+3; returns at the following posedge+3
    task automatic step(input logic en, input logic [5:0] w, input logic s);
        shift_en = en;
        din      = w;
        stb      = s;
        @(posedge dclk);
        if (s && !stb_prev)
            for (int i = 0; i < NN; i++) lat[i] = m[i];   // R7: pre-shift content
        stb_prev = s;
        if (en) begin
            if (!dir_rev) begin
                for (int i = NN-1; i > 0; i--) m[i] = m[i-1];
                m[0] = w;
            end else begin
                for (int i = 0; i < NN-1; i++) m[i] = m[i+1];
                m[NN-1] = w;
            end
        end
        #3;
        if (pad_chk) begin
            if (!dir_rev) begin
                check("R4 fwd cascade pad", 32'(a_hi_out), 32'(m[N-1]));
                check("R4 fwd tail pad",    32'(b_hi_out), 32'(m[NN-1]));
                check("R3 fwd pad roles",   32'({a_hi_oe, a_lo_oe, b_hi_oe, b_lo_oe}), 32'b1010);
            end else begin
                check("R4 rev cascade pad", 32'(b_lo_out), 32'(m[N]));
                check("R4 rev tail pad",    32'(a_lo_out), 32'(m[0]));
                check("R3 rev pad roles",   32'({a_hi_oe, a_lo_oe, b_hi_oe, b_lo_oe}), 32'b0101);
            end
        end
    endtask

    task automatic check_latch(input string tag);
        for (int c = 0; c < N; c++) begin
            check({tag, " R5 chip0"}, 32'({a_cur[2*c +: 2], a_pw[4*c +: 4]}), 32'(lat[c]));
            check({tag, " R5 chip1"}, 32'({b_cur[2*c +: 2], b_pw[4*c +: 4]}), 32'(lat[N+c]));
        end
    endtask

    task automatic set_dir(input logic d);
        pad_chk = 1'b0;
        dir_rev = d;
        step(1'b0, 6'h0, 1'b0);
        step(1'b0, 6'h0, 1'b0);
        pad_chk = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge dclk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dir_rev = 1'b0; shift_en = 1'b0; stb = 1'b0; din = '0;
        clear_model();
        repeat (3) @(posedge dclk);
        #3;
        // R9: reset state
        check("R9 reset oe", 32'({a_hi_oe, a_lo_oe, b_hi_oe, b_lo_oe}), 32'b0);
        check("R9 reset pads", 32'({a_lo_out, a_hi_out, b_lo_out, b_hi_out}), 32'b0);
        check_latch("R9 reset");
        rst_n = 1'b1;
        repeat (4) step(1'b0, 6'h0, 1'b0);

        // R1 forward fill of the two-chip chain
        set_dir(1'b0);
        for (int k = 0; k < NN; k++) step(1'b1, 6'((k * 7 + 3) % 64), 1'b0);
        step(1'b0, 6'h0, 1'b1);
        check_latch("R1 R7 fwd load");

        // R8: strobe held high, further shifts must not reach the held values
        for (int k = 0; k < 3; k++) step(1'b1, 6'(k + 40), 1'b1);
        check_latch("R8 held");

        // R6: shift_en low with changing data leaves the chain alone
        for (int k = 0; k < 4; k++) step(1'b0, 6'(k * 9 + 1), 1'b0);
        step(1'b0, 6'h0, 1'b1);
        check_latch("R6 idle");
        step(1'b0, 6'h0, 1'b0);

        // R7: strobe and shift on the same edge captures pre-shift content
        step(1'b1, 6'h3f, 1'b1);
        step(1'b0, 6'h0, 1'b0);
        check_latch("R7 same edge");

        // R2 reverse fill
        set_dir(1'b1);
        for (int k = 0; k < NN; k++) step(1'b1, 6'((k * 13 + 5) % 64), 1'b0);
        step(1'b0, 6'h0, 1'b1);
        check_latch("R2 R7 rev load");
        step(1'b0, 6'h0, 1'b0);

        // R3: turn back to forward and shift a few words
        set_dir(1'b0);
        for (int k = 0; k < 5; k++) step(1'b1, 6'(k + 50), 1'b0);
        step(1'b0, 6'h0, 1'b1);
        check_latch("R3 turnaround");

        // R9: reset in the middle of operation
        pad_chk = 1'b0;
        rst_n = 1'b0;
        @(posedge dclk);
        #1;
        clear_model();
        check("R9 mid oe", 32'({a_hi_oe, a_lo_oe, b_hi_oe, b_lo_oe}), 32'b0);
        check("R9 mid pads", 32'({a_lo_out, a_hi_out, b_lo_out, b_hi_out}), 32'b0);
        check_latch("R9 mid");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule